// File: doc/BRIEF.md
# Filter Accelerator Control Register Bank

This block is the slave register bank that sits in front of a streaming filter engine. A host writes and reads 32-bit words at byte offsets from the block's base. The bank holds a control/status word whose bit 0 starts the engine, two transfer addresses, a transfer length, and a table of 16-bit filter taps packed two per word. It also reflects, read-only, the occupancy counts of the engine's input and output sample FIFOs.

A DMA sequencer advances the input address and input length through a separate update port as it fetches data. A soft-reset input idles the engine by clearing the control word. It also sends one-cycle flush pulses to both FIFOs and to the filter delay line.

The host side is plain and is never back-pressured: a write is taken in the cycle `wr_en` is high. A read is taken in the cycle `rd_en` is high, and its data returns one cycle later, marked by `rd_valid`. The low two address bits are ignored.

Top module: `filt_ctl_regbank`

## Requirements
- R1: After the hard reset `rst_n` is released, the control word, both addresses, the length and every tap read as zero, and `rd_valid` and all flush outputs are low.
- R2: The word at offset 0x0 is the control/status word and can be written and read back. Output `run` equals its bit 0, and `ctl_word` shows the whole word.
- R3: Offset 0x4 holds the input start address, 0x8 the input length in 32-bit words, and 0xC the output start address. Each can be written and read back, and each is shown on its own output port.
- R4: Tap word k sits at offset 0x10 + 4k. On a write, bits 15:0 go to tap 2k and bits 31:16 go to tap 2k+1. A read returns the two taps in the same layout. Tap i is shown on `coef_flat[16i+15:16i]`.
- R5: There are 9 taps. At the last tap word (0x20), the upper half of a write is dropped, and the upper half of a read returns zero.
- R6: Offset 0x30 reads as {input-FIFO free count in bits 31:16, input-FIFO available count in bits 15:0}. Offset 0x34 reads as {output-FIFO free, output-FIFO available} in the same layout.
- R7: Writes to 0x30, 0x34 or any unmapped offset change no register. Reads of unmapped offsets (0x24 to 0x2C, and 0x38 and above) return zero.
- R8: `rd_valid` is high exactly in the cycle after each cycle with `rd_en` high. While `rd_valid` is low, `rd_data` is zero.
- R9: When `dma_upd` is high, the input address and input length load `dma_in_addr` and `dma_in_len`. A host write to one of these two registers in the same cycle wins for that register only.
- R10: While `soft_rst` is high, the control word is cleared, and a host write to it in the same cycle is lost. Addresses, length and taps keep their values.
- R11: When `soft_rst` rises, `flush_in_fifo`, `flush_out_fifo` and `flush_dline` go high for exactly one cycle, in the cycle after the edge that first samples `soft_rst` high. Holding `soft_rst` high gives no further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset: idles the engine and flushes |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write byte offset |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read byte offset |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| dma_upd | input | 1 | DMA update of input address and length |
| dma_in_addr | input | 32 | New input address from the DMA |
| dma_in_len | input | 32 | New input length from the DMA |
| in_avail | input | 16 | Input FIFO filled entries |
| in_free | input | 16 | Input FIFO free entries |
| out_avail | input | 16 | Output FIFO filled entries |
| out_free | input | 16 | Output FIFO free entries |
| run | output | 1 | Engine enable (control word bit 0) |
| ctl_word | output | 32 | Full control/status word |
| in_addr | output | 32 | Input start address |
| in_len | output | 32 | Input length in words |
| out_addr | output | 32 | Output start address |
| coef_flat | output | 144 | Nine 16-bit taps, tap 0 in the low bits |
| flush_in_fifo | output | 1 | Flush pulse to the input FIFO |
| flush_out_fifo | output | 1 | Flush pulse to the output FIFO |
| flush_dline | output | 1 | Clear pulse to the filter delay line |

## Verification
Two functions can act on the same register in the same cycle. A host write to 0x4 or 0x8 can coincide with a DMA update, and a host write to the control word can coincide with soft reset. The bench drives each pair in one cycle, both in directed cases and in the random mix. It then judges the result from the output ports and from read-back. The host write must survive only in the register it addressed, the DMA value must land in the other register, and the control word must read zero after a soft reset.

// File: rtl/filt_regs_pkg.sv
package filt_regs_pkg;
  parameter int DATA_W   = 32;
  parameter int TAP_W    = 16;
  // word indices (byte offset / 4) of the fixed control region
  parameter int W_CTL    = 0;
  parameter int W_INADR  = 1;
  parameter int W_INLEN  = 2;
  parameter int W_OUTADR = 3;
  parameter int W_TAP0   = 4;
  parameter int W_CNTIN  = 12;
  parameter int W_CNTOUT = 13;
endpackage

// File: rtl/filt_tap_bank.sv
module filt_tap_bank
  import filt_regs_pkg::*;
#(
  parameter int NTAP = 9,
  parameter int IW   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IW-1:0]           widx,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [IW-1:0]           ridx,
  output logic [DATA_W-1:0]       rword,
  output logic [NTAP*TAP_W-1:0]   taps_flat
);
  localparam int NWORD = (NTAP + 1) / 2;

  logic [TAP_W-1:0]  tap_q [NTAP];
  logic [DATA_W-1:0] words [NWORD];

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tap_q[i] <= '0;
      else if (we && widx == IW'(i / 2))
        tap_q[i] <= ((i % 2) == 1) ? wdata[DATA_W-1:TAP_W] : wdata[TAP_W-1:0];
    end
    assign taps_flat[i*TAP_W +: TAP_W] = tap_q[i];
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    if (2*w + 1 < NTAP) begin : g_pair
      assign words[w] = {tap_q[2*w+1], tap_q[2*w]};
    end else begin : g_single
      assign words[w] = {{TAP_W{1'b0}}, tap_q[2*w]};
    end
  end

  always_comb begin
    rword = '0;
    for (int w = 0; w < NWORD; w++)
      if (ridx == IW'(w)) rword = words[w];
  end

  // R4: a write to tap word 0 loads tap 0 from the low half, tap 1 from the high half
  a_r4_pair_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == '0) |=> (tap_q[0] == $past(wdata[TAP_W-1:0]) &&
                            tap_q[1] == $past(wdata[DATA_W-1:TAP_W])));
endmodule

// File: rtl/filt_flush_gen.sv
module filt_flush_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  output logic pulse
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      seen_q <= soft_rst;
      pulse  <= soft_rst && !seen_q;
    end
  end

  // R11: flush is a single-cycle pulse
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R11: a rising soft reset yields a pulse in the next cycle
  a_r11_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !seen_q) |=> pulse);
endmodule

// File: rtl/filt_rd_mux.sv
module filt_rd_mux
  import filt_regs_pkg::*;
#(
  parameter int WW    = 6,
  parameter int NWORD = 5
) (
  input  logic [WW-1:0]     word,
  input  logic [DATA_W-1:0] ctl,
  input  logic [DATA_W-1:0] inadr,
  input  logic [DATA_W-1:0] inlen,
  input  logic [DATA_W-1:0] outadr,
  input  logic [DATA_W-1:0] tapword,
  input  logic [TAP_W-1:0]  in_avail,
  input  logic [TAP_W-1:0]  in_free,
  input  logic [TAP_W-1:0]  out_avail,
  input  logic [TAP_W-1:0]  out_free,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    dout = '0;
    if (word == WW'(W_CTL))         dout = ctl;
    else if (word == WW'(W_INADR))  dout = inadr;
    else if (word == WW'(W_INLEN))  dout = inlen;
    else if (word == WW'(W_OUTADR)) dout = outadr;
    else if (word >= WW'(W_TAP0) && word < WW'(W_TAP0 + NWORD)) dout = tapword;
    else if (word == WW'(W_CNTIN))  dout = {in_free, in_avail};
    else if (word == WW'(W_CNTOUT)) dout = {out_free, out_avail};
  end
endmodule

// File: rtl/filt_ctl_regbank.sv
module filt_ctl_regbank
  import filt_regs_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NTAP = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  dma_upd,
  input  logic [DATA_W-1:0]     dma_in_addr,
  input  logic [DATA_W-1:0]     dma_in_len,
  input  logic [TAP_W-1:0]      in_avail,
  input  logic [TAP_W-1:0]      in_free,
  input  logic [TAP_W-1:0]      out_avail,
  input  logic [TAP_W-1:0]      out_free,
  output logic                  run,
  output logic [DATA_W-1:0]     ctl_word,
  output logic [DATA_W-1:0]     in_addr,
  output logic [DATA_W-1:0]     in_len,
  output logic [DATA_W-1:0]     out_addr,
  output logic [NTAP*TAP_W-1:0] coef_flat,
  output logic                  flush_in_fifo,
  output logic                  flush_out_fifo,
  output logic                  flush_dline
);
  localparam int WW    = AW - 2;
  localparam int NWORD = (NTAP + 1) / 2;

  logic [WW-1:0]     wword, rword;
  logic              hit_ctl, hit_ia, hit_len, hit_oa, tap_we;
  logic [WW-1:0]     tap_widx, tap_ridx;
  logic [DATA_W-1:0] tap_rd, mux_out;
  logic              flush_p;

  assign wword    = wr_addr[AW-1:2];
  assign rword    = rd_addr[AW-1:2];
  assign hit_ctl  = wr_en && wword == WW'(W_CTL);
  assign hit_ia   = wr_en && wword == WW'(W_INADR);
  assign hit_len  = wr_en && wword == WW'(W_INLEN);
  assign hit_oa   = wr_en && wword == WW'(W_OUTADR);
  assign tap_we   = wr_en && wword >= WW'(W_TAP0) && wword < WW'(W_TAP0 + NWORD);
  assign tap_widx = wword - WW'(W_TAP0);
  assign tap_ridx = rword - WW'(W_TAP0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_word <= '0;
      in_addr  <= '0;
      in_len   <= '0;
      out_addr <= '0;
    end else begin
      if (soft_rst)     ctl_word <= '0;
      else if (hit_ctl) ctl_word <= wr_data;
      if (hit_ia)       in_addr  <= wr_data;
      else if (dma_upd) in_addr  <= dma_in_addr;
      if (hit_len)      in_len   <= wr_data;
      else if (dma_upd) in_len   <= dma_in_len;
      if (hit_oa)       out_addr <= wr_data;
    end
  end
  assign run = ctl_word[0];

  filt_tap_bank #(.NTAP(NTAP), .IW(WW)) u_taps (
    .clk(clk), .rst_n(rst_n), .we(tap_we), .widx(tap_widx), .wdata(wr_data),
    .ridx(tap_ridx), .rword(tap_rd), .taps_flat(coef_flat)
  );

  filt_rd_mux #(.WW(WW), .NWORD(NWORD)) u_rmux (
    .word(rword), .ctl(ctl_word), .inadr(in_addr), .inlen(in_len), .outadr(out_addr),
    .tapword(tap_rd), .in_avail(in_avail), .in_free(in_free),
    .out_avail(out_avail), .out_free(out_free), .dout(mux_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? mux_out : '0;
    end
  end

  filt_flush_gen u_flush (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pulse(flush_p));
  assign flush_in_fifo  = flush_p;
  assign flush_out_fifo = flush_p;
  assign flush_dline    = flush_p;

  // R2: a control write without soft reset sets run from data bit 0
  a_r2_run_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[AW-1:2] == WW'(W_CTL) && !soft_rst) |=> run == $past(wr_data[0]));
  // R10: soft reset leaves the control word zero
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ctl_word == '0);
  // R8: read data arrives one cycle after the request
  a_r8_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rd_data == '0));
  // R9: DMA value lands unless the host addressed that register
  a_r9_dma_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_upd && !(wr_en && wr_addr[AW-1:2] == WW'(W_INADR))) |=> in_addr == $past(dma_in_addr));
  a_r9_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[AW-1:2] == WW'(W_INLEN)) |=> in_len == $past(wr_data));
  // R6: input FIFO counts read back packed free:avail
  a_r6_cnt_in: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[AW-1:2] == WW'(W_CNTIN)) |=> rd_data == {$past(in_free), $past(in_avail)});
  // R5: last tap word has an empty upper half when the tap count is odd
  if (NTAP % 2 == 1) begin : g_odd_chk
    a_r5_top_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr[AW-1:2] == WW'(W_TAP0 + NWORD - 1)) |=> rd_data[DATA_W-1:TAP_W] == '0);
  end
endmodule

// File: tb/filt_ctl_regbank_tb_top.sv
module filt_ctl_regbank_tb_top;
  localparam int NT = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, dma_upd = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, dma_in_addr = '0, dma_in_len = '0;
  logic [15:0] in_avail = '0, in_free = '0, out_avail = '0, out_free = '0;
  logic        rd_valid, run, flush_in_fifo, flush_out_fifo, flush_dline;
  logic [31:0] rd_data, ctl_word, in_addr, in_len, out_addr;
  logic [NT*16-1:0] coef_flat;

  filt_ctl_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .dma_upd(dma_upd), .dma_in_addr(dma_in_addr),
    .dma_in_len(dma_in_len), .in_avail(in_avail), .in_free(in_free),
    .out_avail(out_avail), .out_free(out_free), .run(run), .ctl_word(ctl_word),
    .in_addr(in_addr), .in_len(in_len), .out_addr(out_addr), .coef_flat(coef_flat),
    .flush_in_fifo(flush_in_fifo), .flush_out_fifo(flush_out_fifo), .flush_dline(flush_dline)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_ctl = '0, m_ia = '0, m_len = '0, m_oa = '0;
  logic [15:0] m_tap [NT];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a[7:2]);
    if (w == 0) m_ctl = d;
    else if (w == 1) m_ia = d;
    else if (w == 2) m_len = d;
    else if (w == 3) m_oa = d;
    else if (w >= 4 && w < 4 + (NT+1)/2) begin
      m_tap[2*(w-4)] = d[15:0];
      if (2*(w-4)+1 < NT) m_tap[2*(w-4)+1] = d[31:16];
    end
  endfunction

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    int w = int'(a[7:2]);
    if (w == 0) return m_ctl;
    if (w == 1) return m_ia;
    if (w == 2) return m_len;
    if (w == 3) return m_oa;
    if (w >= 4 && w < 4 + (NT+1)/2)
      return {(2*(w-4)+1 < NT) ? m_tap[2*(w-4)+1] : 16'h0, m_tap[2*(w-4)]};
    if (w == 12) return {in_free, in_avail};
    if (w == 13) return {out_free, out_avail};
    return 32'h0;
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_wr(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    e = model_rd(a);
    chk(rd_valid == 1'b1, {tag, " rd_valid"}, {31'h0, rd_valid}, 32'h1);
    chk(rd_data == e, tag, rd_data, e);
  endtask

  task automatic ports_chk(input string tag);
    chk(in_addr == m_ia, {tag, " in_addr"}, in_addr, m_ia);
    chk(in_len == m_len, {tag, " in_len"}, in_len, m_len);
    chk(out_addr == m_oa, {tag, " out_addr"}, out_addr, m_oa);
    chk(ctl_word == m_ctl, {tag, " ctl_word"}, ctl_word, m_ctl);
    for (int i = 0; i < NT; i++)
      chk(coef_flat[16*i +: 16] == m_tap[i], {tag, " tap"}, {16'h0, coef_flat[16*i +: 16]}, {16'h0, m_tap[i]});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NT; i++) m_tap[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    ports_chk("R1 reset");
    chk(rd_valid == 1'b0, "R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    chk(flush_dline == 1'b0, "R1 flush", {31'h0, flush_dline}, 32'h0);

    // R2/R3: directed writes and readback
    bus_wr(8'h00, 32'hA5A5_0001);
    chk(run == 1'b1, "R2 run", {31'h0, run}, 32'h1);
    rd_chk(8'h00, "R2 ctl");
    bus_wr(8'h04, 32'h1000_0040);
    bus_wr(8'h08, 32'h0000_0100);
    bus_wr(8'h0C, 32'h2000_0000);
    rd_chk(8'h04, "R3 in_addr"); rd_chk(8'h08, "R3 in_len"); rd_chk(8'h0C, "R3 out_addr");
    ports_chk("R3 ports");
    // R8: valid is gone the cycle after a read
    @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == 32'h0, "R8 idle", rd_data, 32'h0);

    // R4/R5: taps, including the dropped upper half at the last word
    for (int k = 0; k < 5; k++) bus_wr(8'(8'h10 + 4*k), {16'h1000 + 16'(k), 16'h0100 + 16'(k)});
    ports_chk("R4 taps");
    for (int k = 0; k < 5; k++) rd_chk(8'(8'h10 + 4*k), "R4 tap word");
    bus_wr(8'h20, 32'hDEAD_BEEF);
    chk(coef_flat[8*16 +: 16] == 16'hBEEF, "R5 last tap", {16'h0, coef_flat[8*16 +: 16]}, 32'hBEEF);
    rd_chk(8'h20, "R5 last word");

    // R6: counts
    in_avail = 16'h0012; in_free = 16'h000E; out_avail = 16'h0003; out_free = 16'h000D;
    rd_chk(8'h30, "R6 in counts"); rd_chk(8'h34, "R6 out counts");

    // R7: ignored writes, zero reads
    bus_wr(8'h30, 32'hFFFF_FFFF); bus_wr(8'h34, 32'h1234_5678);
    bus_wr(8'h24, 32'hCAFE_F00D); bus_wr(8'hFC, 32'h5555_AAAA);
    ports_chk("R7 ignored");
    rd_chk(8'h30, "R7 counts kept"); rd_chk(8'h24, "R7 unmapped"); rd_chk(8'h2C, "R7 unmapped");
    rd_chk(8'hFC, "R7 unmapped");

    // R9: DMA alone, then DMA together with a host write to the address
    @(negedge clk);
    dma_upd = 1'b1; dma_in_addr = 32'h3000_0000; dma_in_len = 32'h0000_00F0;
    m_ia = dma_in_addr; m_len = dma_in_len;
    @(negedge clk);
    dma_upd = 1'b0;
    ports_chk("R9 dma");
    dma_upd = 1'b1; dma_in_addr = 32'h3000_0040; dma_in_len = 32'h0000_00E0;
    wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h7777_0000;
    m_ia = 32'h7777_0000; m_len = 32'h0000_00E0;
    @(negedge clk);
    dma_upd = 1'b0; wr_en = 1'b0;
    ports_chk("R9 host wins");

    // R10/R11: soft reset with a same-cycle control write, held three cycles
    bus_wr(8'h00, 32'h0000_0003);
    soft_rst = 1'b1; wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h0000_0001;
    m_ctl = '0;
    @(negedge clk);
    wr_en = 1'b0;
    chk(run == 1'b0 && ctl_word == 32'h0, "R10 ctl cleared", ctl_word, 32'h0);
    chk(flush_in_fifo && flush_out_fifo && flush_dline, "R11 pulse",
        {29'h0, flush_in_fifo, flush_out_fifo, flush_dline}, 32'h7);
    @(negedge clk);
    chk(!flush_in_fifo && !flush_out_fifo && !flush_dline, "R11 single",
        {29'h0, flush_in_fifo, flush_out_fifo, flush_dline}, 32'h0);
    @(negedge clk);
    chk(!flush_dline, "R11 held", {31'h0, flush_dline}, 32'h0);
    soft_rst = 1'b0;
    ports_chk("R10 kept");

    // random mix: R2 R3 R4 R7 R9 R10
    for (int it = 0; it < 400; it++) begin
      logic [7:0] a;
      int op = int'($urandom_range(0, 9));
      a = {$urandom_range(0, 15) == 0 ? 6'($urandom) : 6'($urandom_range(0, 14)), 2'($urandom)};
      in_avail = 16'($urandom); in_free = 16'($urandom);
      if (op < 4) bus_wr(a, $urandom);
      else if (op < 7) rd_chk(a, "R7 R4 random read");
      else if (op < 9) begin
        @(negedge clk);
        dma_upd = 1'b1; dma_in_addr = $urandom; dma_in_len = $urandom;
        wr_en = $urandom_range(0, 1) == 1; wr_addr = a; wr_data = $urandom;
        m_ia = dma_in_addr; m_len = dma_in_len;
        if (wr_en) model_wr(a, wr_data);
        @(negedge clk);
        dma_upd = 1'b0; wr_en = 1'b0;
        ports_chk("R9 random");
      end else begin
        @(negedge clk);
        soft_rst = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = $urandom;
        model_wr(a, wr_data); m_ctl = '0;
        @(negedge clk);
        soft_rst = 1'b0; wr_en = 1'b0;
        ports_chk("R10 random");
      end
    end
    ports_chk("R3 final");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule